// File: doc/BRIEF.md
# Bidirectional Full-Cycle Pseudorandom Counter

This block is a 4-bit pseudorandom counter. It is built as a shift register whose stages each take their next value from a per-stage selector. On every enabled clock edge the register moves one place, either toward bit 0 or toward bit 3. A single mode pin picks the direction. The bit that enters at the open end is produced by XOR feedback.

The feedback carries a zero-state correction term. Because of it, the counter also passes through 0000 and covers all 16 codes before it repeats, in either direction. The two feedback networks are built as exact inverses of each other. A step one way followed by a step the other way therefore returns the starting code, so the mode pin can walk the same cycle forward or backward.

The block has no data stream and no handshake. Every pin is a plain control or state signal.

Top module: `ucnt_lfsr4`

## Requirements
- R1: A high `rst` at a rising clock edge sets `state` to 0000 on that edge, whatever `cnt_en` and `dir_left` are.
- R2: With `rst` low and `cnt_en` low, `state` keeps its value across the edge.
- R3: With `dir_left` = 0 (right mode) and `cnt_en` high, each new bit k (k = 0..2) equals old bit k+1. New bit 3 equals old bit 0 XOR old bit 1, inverted when old bits 3..1 are all zero.
- R4: With `dir_left` = 1 (left mode) and `cnt_en` high, each new bit k (k = 1..3) equals old bit k-1. New bit 0 equals old bit 3 XOR old bit 0, inverted when old bits 2..0 are all zero.
- R5: In right mode, 0000 steps to 1000 and 0001 steps to 0000.
- R6: In left mode, 0000 steps to 0001 and 1000 steps to 0000.
- R7: Starting from 0000, sixteen enabled steps in one fixed direction visit 16 distinct codes and end back at 0000.
- R8: From any code, one right step followed by one left step gives back the starting code. The same holds for a left step followed by a right step.
- R9: A change of `dir_left` alone does not alter `state`. The new direction applies from the next enabled edge onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset to 0000, active high |
| cnt_en | input | 1 | Count enable; the state advances one step when high |
| dir_left | input | 1 | Direction: 0 shifts toward bit 0, 1 shifts toward bit 3 |
| state | output | 4 | Current counter code |

## Verification
The bench targets the two ends of the correction window in each direction: 0000 and the code just before it (0001 in right mode, 1000 in left mode). A design that lacks the correction would lock up at 0000. A design whose correction is too wide would skip or repeat a code, and a full 16-step lap then shows a duplicate or fails to return to 0000.

Round trips through every code catch a left network that only mirrors the right taps instead of inverting them; such a design walks a different cycle backward and does not return to its start. The bench also toggles the mode pin while counting is disabled, and applies reset while counting is enabled. A design that lets the mode or the enable leak into the hold or reset path changes state at those moments.

// File: rtl/ucnt_pkg.sv
package ucnt_pkg;
  localparam int W = 4;
  typedef logic [W-1:0] state_t;
  typedef enum logic {DIR_RIGHT = 1'b0, DIR_LEFT = 1'b1} dir_e;
  // feedback tap positions per direction
  localparam int R_TAP_A = 0;
  localparam int R_TAP_B = 1;
  localparam int L_TAP_A = W - 1;
  localparam int L_TAP_B = 0;
endpackage

// File: rtl/ucnt_feedback.sv
module ucnt_feedback
  import ucnt_pkg::*;
(
  input  state_t s,
  output logic   fb_right,
  output logic   fb_left
);
  logic upper_zero;
  logic lower_zero;

  // zero detect over the bits that remain after the shift
  assign upper_zero = (s[W-1:1] == '0);
  assign lower_zero = (s[W-2:0] == '0);

  always_comb begin
    fb_right = s[R_TAP_A] ^ s[R_TAP_B] ^ upper_zero;
    fb_left  = s[L_TAP_A] ^ s[L_TAP_B] ^ lower_zero;
  end
endmodule

// File: rtl/ucnt_stage.sv
module ucnt_stage
  import ucnt_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  dir_e dir,
  input  logic from_right,
  input  logic from_left,
  output logic q
);
  logic nxt;

  always_comb begin
    nxt = q;
    if (en) begin
      nxt = (dir == DIR_LEFT) ? from_left : from_right;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) q <= 1'b0;
    else     q <= nxt;
  end
endmodule

// File: rtl/ucnt_lfsr4.sv
module ucnt_lfsr4
  import ucnt_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       cnt_en,
  input  logic       dir_left,
  output logic [3:0] state
);
  state_t state_q;
  logic   fb_r;
  logic   fb_l;
  dir_e   dir_sel;

  assign dir_sel = dir_e'(dir_left);

  ucnt_feedback fb_i (
    .s        (state_q),
    .fb_right (fb_r),
    .fb_left  (fb_l)
  );

  for (genvar k = 0; k < W; k++) begin : g_bit
    logic src_r;
    logic src_l;
    if (k == W - 1) begin : g_rtop
      assign src_r = fb_r;
    end else begin : g_rmid
      assign src_r = state_q[k+1];
    end
    if (k == 0) begin : g_lbot
      assign src_l = fb_l;
    end else begin : g_lmid
      assign src_l = state_q[k-1];
    end
    ucnt_stage st_i (
      .clk        (clk),
      .rst        (rst),
      .en         (cnt_en),
      .dir        (dir_sel),
      .from_right (src_r),
      .from_left  (src_l),
      .q          (state_q[k])
    );
  end

  assign state = state_q;
endmodule

module ucnt_lfsr4_chk (
  input logic       clk,
  input logic       rst,
  input logic       cnt_en,
  input logic       dir_left,
  input logic [3:0] state
);
  logic rst_d;
  always_ff @(posedge clk) rst_d <= rst;

  // R1
  always @(negedge clk) begin
    if (rst_d === 1'b1) begin
      reset_zero_chk: assert (state == 4'b0000);
    end
  end

  // R2
  hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
    !cnt_en |=> $stable(state));

  // R3
  shift_right_chk: assert property (@(posedge clk) disable iff (rst)
    (cnt_en && !dir_left) |=> state[2:0] == $past(state[3:1]));

  // R4
  shift_left_chk: assert property (@(posedge clk) disable iff (rst)
    (cnt_en && dir_left) |=> state[3:1] == $past(state[2:0]));

  // R5
  right_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (cnt_en && !dir_left && state == 4'b0001) |=> state == 4'b0000);

  // R5
  right_exit_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (cnt_en && !dir_left && state == 4'b0000) |=> state == 4'b1000);

  // R6
  left_exit_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (cnt_en && dir_left && state == 4'b0000) |=> state == 4'b0001);

  // R7
  no_lockup_chk: assert property (@(posedge clk) disable iff (rst)
    (cnt_en && state == 4'b0000) |=> state != 4'b0000);
endmodule

bind ucnt_lfsr4 ucnt_lfsr4_chk chk_i (.*);

// File: tb/ucnt_lfsr4_tb_top.sv
module ucnt_lfsr4_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cnt_en = 1'b0;
  logic       dir_left = 1'b0;
  logic [3:0] state;

  int compared = 0;
  int mismatched = 0;
  logic [3:0] exp_state = 4'b0000;
  logic [3:0] exp_q[$];
  string      tag_q[$];
  bit         done = 1'b0;

  always #10 clk = ~clk;

  ucnt_lfsr4 dut_i (
    .clk(clk), .rst(rst), .cnt_en(cnt_en), .dir_left(dir_left), .state(state)
  );

  function automatic logic [3:0] model(input logic [3:0] s, input logic r,
                                       input logic e, input logic d);
    if (r) return 4'b0000;
    if (!e) return s;
    if (!d) return {s[0] ^ s[1] ^ (s[3:1] == 3'b000), s[3:1]};
    return {s[2:0], s[3] ^ s[0] ^ (s[2:0] == 3'b000)};
  endfunction

  task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic drive(input logic r, input logic e, input logic d, input string req);
    @(negedge clk);
    rst = r; cnt_en = e; dir_left = d;
    exp_state = model(exp_state, r, e, d);
    @(posedge clk);
    #1;
    exp_q.push_back(exp_state);
    tag_q.push_back(req);
  endtask

  // monitor
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      logic [3:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      check(t, state, e);
    end
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      compared++; mismatched++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    logic [15:0] seen;
    logic [3:0]  start;
    drive(1, 1, 0, "R1 reset");
    drive(1, 0, 1, "R1 reset");
    // right-mode lap from zero
    drive(0, 1, 0, "R5 0000->1000");
    check("R5 first right step", state, 4'b1000);
    seen = 16'h0001 | (16'h1 << state);
    for (int i = 1; i < 16; i++) begin
      drive(0, 1, 0, "R3 right step");
      if (i < 15) seen |= (16'h1 << state);
    end
    check("R7 right lap back at 0000", state, 4'b0000);
    check("R7 right lap distinct codes", seen[3:0] ^ 4'h0, 4'hf);
    check("R7 right lap all 16", {3'b0, &seen}, 4'b0001);
    // hold and mode toggles while disabled
    drive(0, 1, 0, "R3 right step");
    drive(0, 0, 1, "R2 hold");
    drive(0, 0, 0, "R9 mode toggle no effect");
    drive(0, 0, 1, "R9 mode toggle no effect");
    drive(0, 1, 1, "R9 new mode on enabled edge");
    // reset while counting
    drive(1, 1, 1, "R1 reset over enable");
    // left lap
    drive(0, 1, 1, "R6 0000->0001");
    check("R6 first left step", state, 4'b0001);
    seen = 16'h0001 | (16'h1 << state);
    for (int i = 1; i < 16; i++) begin
      if (i == 15) check("R6 code before wrap", state, 4'b1000);
      drive(0, 1, 1, "R4 left step");
      if (i < 15) seen |= (16'h1 << state);
    end
    check("R7 left lap back at 0000", state, 4'b0000);
    check("R7 left lap all 16", {3'b0, &seen}, 4'b0001);
    // round trips from every code
    for (int i = 0; i < 16; i++) begin
      start = state;
      drive(0, 1, 0, "R3 right step");
      drive(0, 1, 1, "R4 left step");
      check("R8 right then left", state, start);
      drive(0, 1, 1, "R4 left step");
      drive(0, 1, 0, "R3 right step");
      check("R8 left then right", state, start);
      drive(0, 1, 0, "R3 advance");
    end
    drive(0, 0, 0, "R2 hold");
    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule